// File: doc/BRIEF.md
# Time-Slot Memory Bandwidth Arbiter

This block shares one memory port among up to fifteen requesters. The share each requester gets is set by a programmable table of 64 time slots. A slot pointer walks the table one entry per completed grant. When the arbiter is idle and a request is pending, it looks at the entry under the pointer. If that entry names a client that is requesting, that client wins. Otherwise the slot is not wasted: the lowest-numbered requesting client takes it. A client that owns no slot therefore still gets service whenever slot owners leave their slots unclaimed.

Each grant covers one burst. A grant is held until the client flags its final beat, or until the beat count reaches that client's programmed burst limit. The slot entries and the burst limits are written through simple indexed write ports. They may be rewritten at run time while traffic flows, which lets software move bandwidth between clients as they are added or removed. The memory controller, the address and data paths, and the software that computes the table are outside this block.

Top module: `slot_arbiter`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `gnt` is zero, `gnt_owned` is 0 and `slot_ptr` is 0. Every slot reads as unassigned after reset.
- R2: When no grant is active, requests are pending and the entry at `slot_ptr` names a requesting client, that client is granted one cycle later with `gnt_owned` = 1.
- R3: When no grant is active, requests are pending and the entry at `slot_ptr` names a client that is not requesting, the lowest-index requesting client is granted one cycle later with `gnt_owned` = 0.
- R4: A slot holding a client code of 15 or more, or never written since reset, is unassigned and always resolves as in R3.
- R5: At most one bit of `gnt` is high at any time.
- R6: An active grant stays unchanged on every cycle without an accepted beat (`beat_valid` = 0).
- R7: The burst limit value L of a client allows L+1 beats per grant. Limits reset to 3, meaning four beats. `blen_we` writes `blen_value` into the limit of client `blen_client`.
- R8: `slot_ptr` advances by one when a grant is released, wrapping from 63 to 0. It never moves while no grant is active.
- R9: A slot write (`slot_we`, `slot_addr`, `slot_client`) sets that entry from the following cycle on. This also holds while grants are in progress.
- R10: A grant is released after the accepted beat that has `beat_last` = 1 or that reaches the beat limit. `gnt` is then zero for one cycle. With no requests, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 15 | Per-client request lines |
| beat_valid | input | 1 | A data beat of the granted burst is accepted this cycle |
| beat_last | input | 1 | The accepted beat is the client's final beat |
| slot_we | input | 1 | Slot entry write strobe |
| slot_addr | input | 6 | Slot index to write |
| slot_client | input | 4 | Client code for the slot (15 = unassigned) |
| blen_we | input | 1 | Burst limit write strobe |
| blen_client | input | 4 | Client whose limit is written |
| blen_value | input | 4 | Burst limit, beats minus one |
| gnt | output | 15 | One-hot grant, registered |
| gnt_owned | output | 1 | The current grant came from the slot table |
| slot_ptr | output | 6 | Current slot table position |

## Verification
A wrong slot pointer or a stale table entry shows up on the first idle-to-grant decision after the fault: the wrong client is granted, or `gnt_owned` has the wrong value. A beat counter or limit register that is off changes the release cycle. That shifts `gnt` and `slot_ptr` by at least one cycle within a single burst. The bench keeps its own model of the table, limits, pointer and beat count. It compares all three outputs on every clock, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/slotarb_pkg.sv
package slotarb_pkg;
  localparam int DEF_CLIENTS    = 15;
  localparam int DEF_SLOTS      = 64;
  localparam int DEF_BURST_W    = 4;
  localparam int DEF_BURST_INIT = 3;
endpackage

// File: rtl/slotarb_table.sv
module slotarb_table #(
  parameter int SLOTS  = 64,
  parameter int ADDR_W = $clog2(SLOTS),
  parameter int CID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CID_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_next,
  output logic [CID_W-1:0]  rd_entry,
  output logic              rd_valid
);
  logic [CID_W-1:0] mem [SLOTS];
  logic [SLOTS-1:0] written_q;
  logic [CID_W-1:0] rd_q;
  logic             vld_q;
  logic             same_addr;

  assign same_addr = we && (waddr == raddr_next);

  // data array: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= same_addr ? wdata : mem[raddr_next];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      vld_q <= written_q[raddr_next] | same_addr;
    end
  end

  assign rd_entry = rd_q;
  assign rd_valid = vld_q;
endmodule

// File: rtl/slotarb_lowest.sv
module slotarb_lowest #(
  parameter int N    = 15,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [ID_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = ID_W'(i);
    end
  end
endmodule

// File: rtl/slotarb_limits.sv
module slotarb_limits #(
  parameter int N    = 15,
  parameter int ID_W = 4,
  parameter int BW   = 4,
  parameter int INIT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [ID_W-1:0] widx,
  input  logic [BW-1:0]   wval,
  input  logic [ID_W-1:0] rd_idx,
  output logic [BW-1:0]   rd_lim
);
  logic [BW-1:0] lim_q [N];

  for (genvar g = 0; g < N; g++) begin : g_lim
    always_ff @(posedge clk) begin
      if (rst)                             lim_q[g] <= BW'(INIT);
      else if (we && widx == ID_W'(g))     lim_q[g] <= wval;
    end
  end

  always_comb begin
    rd_lim = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx == ID_W'(i)) rd_lim = lim_q[i];
    end
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slotarb_pkg::*;
#(
  parameter int CLIENTS    = DEF_CLIENTS,
  parameter int SLOTS      = DEF_SLOTS,
  parameter int BURST_W    = DEF_BURST_W,
  parameter int BURST_INIT = DEF_BURST_INIT,
  parameter int CID_W      = $clog2(CLIENTS + 1),
  parameter int SLOT_W     = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CLIENTS-1:0] req,
  input  logic               beat_valid,
  input  logic               beat_last,
  input  logic               slot_we,
  input  logic [SLOT_W-1:0]  slot_addr,
  input  logic [CID_W-1:0]   slot_client,
  input  logic               blen_we,
  input  logic [CID_W-1:0]   blen_client,
  input  logic [BURST_W-1:0] blen_value,
  output logic [CLIENTS-1:0] gnt,
  output logic               gnt_owned,
  output logic [SLOT_W-1:0]  slot_ptr
);
  localparam int REQ_EXT = 1 << CID_W;

  logic                busy_q;
  logic [CID_W-1:0]    gid_q;
  logic [BURST_W-1:0]  cnt_q;
  logic [CLIENTS-1:0]  gnt_q;
  logic                owned_q;
  logic [SLOT_W-1:0]   ptr_q;

  logic [CID_W-1:0]    entry;
  logic                entry_vld;
  logic                any_req;
  logic [CID_W-1:0]    low_idx;
  logic [BURST_W-1:0]  cur_lim;
  logic [REQ_EXT-1:0]  req_ext;
  logic                hit;
  logic [CID_W-1:0]    win;
  logic                release_now;
  logic [SLOT_W-1:0]   ptr_inc;
  logic [SLOT_W-1:0]   ptr_d;
  logic [SLOT_W-1:0]   raddr_next;

  slotarb_table #(.SLOTS(SLOTS), .ADDR_W(SLOT_W), .CID_W(CID_W)) u_table (
    .clk(clk), .rst(rst), .we(slot_we), .waddr(slot_addr), .wdata(slot_client),
    .raddr_next(raddr_next), .rd_entry(entry), .rd_valid(entry_vld)
  );

  slotarb_lowest #(.N(CLIENTS), .ID_W(CID_W)) u_lowest (
    .req(req), .any(any_req), .idx(low_idx)
  );

  slotarb_limits #(.N(CLIENTS), .ID_W(CID_W), .BW(BURST_W), .INIT(BURST_INIT)) u_limits (
    .clk(clk), .rst(rst), .we(blen_we), .widx(blen_client), .wval(blen_value),
    .rd_idx(gid_q), .rd_lim(cur_lim)
  );

  assign req_ext = REQ_EXT'(req);
  // codes at or above CLIENTS have no request line and never hit
  assign hit = entry_vld && (entry < CID_W'(CLIENTS)) && req_ext[entry];
  assign win = hit ? entry : low_idx;

  assign release_now = busy_q && beat_valid && (beat_last || (cnt_q >= cur_lim));
  assign ptr_inc     = (ptr_q == SLOT_W'(SLOTS - 1)) ? '0 : ptr_q + SLOT_W'(1);
  assign ptr_d       = release_now ? ptr_inc : ptr_q;
  assign raddr_next  = rst ? '0 : ptr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      gid_q   <= '0;
      cnt_q   <= '0;
      gnt_q   <= '0;
      owned_q <= 1'b0;
      ptr_q   <= '0;
    end else if (busy_q) begin
      if (beat_valid) begin
        if (release_now) begin
          busy_q  <= 1'b0;
          gnt_q   <= '0;
          owned_q <= 1'b0;
          cnt_q   <= '0;
          ptr_q   <= ptr_d;
        end else begin
          cnt_q <= cnt_q + BURST_W'(1);
        end
      end
    end else if (any_req) begin
      busy_q  <= 1'b1;
      gid_q   <= win;
      gnt_q   <= CLIENTS'(1) << win;
      owned_q <= hit;
      cnt_q   <= '0;
    end
  end

  assign gnt       = gnt_q;
  assign gnt_owned = owned_q;
  assign slot_ptr  = ptr_q;
endmodule

// File: rtl/slot_arbiter_chk.sv
module slot_arbiter_chk #(
  parameter int CLIENTS = 15,
  parameter int SLOTS   = 64,
  parameter int SLOT_W  = $clog2(SLOTS)
) (
  input logic               clk,
  input logic               rst,
  input logic [CLIENTS-1:0] req,
  input logic               beat_valid,
  input logic               beat_last,
  input logic [CLIENTS-1:0] gnt,
  input logic               gnt_owned,
  input logic [SLOT_W-1:0]  slot_ptr
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && !beat_valid) |=> $stable(gnt));

  p_idle_ptr_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0) |=> $stable(slot_ptr));

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && beat_valid && beat_last) |=>
      (slot_ptr == (($past(slot_ptr) == SLOT_W'(SLOTS - 1)) ? '0 : $past(slot_ptr) + SLOT_W'(1))));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && beat_valid && beat_last) |=> (gnt == '0));

  p_no_req_r10: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req == '0) |=> (gnt == '0));

  p_grant_req_r2: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0 && req != '0) |=> ((gnt & $past(req)) != '0));

  p_owned_r2: assert property (@(posedge clk) disable iff (rst)
    gnt_owned |-> (gnt != '0));
endmodule

bind slot_arbiter slot_arbiter_chk #(.CLIENTS(CLIENTS), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .beat_valid(beat_valid), .beat_last(beat_last),
  .gnt(gnt), .gnt_owned(gnt_owned), .slot_ptr(slot_ptr)
);

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb;
  localparam int NC = 15;
  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] req = '0;
  logic        beat_valid = 1'b0, beat_last = 1'b0;
  logic        slot_we = 1'b0;
  logic [5:0]  slot_addr = '0;
  logic [3:0]  slot_client = '0;
  logic        blen_we = 1'b0;
  logic [3:0]  blen_client = '0;
  logic [3:0]  blen_value = '0;
  logic [14:0] gnt;
  logic        gnt_owned;
  logic [5:0]  slot_ptr;

  slot_arbiter u_dut (
    .clk(clk), .rst(rst), .req(req), .beat_valid(beat_valid), .beat_last(beat_last),
    .slot_we(slot_we), .slot_addr(slot_addr), .slot_client(slot_client),
    .blen_we(blen_we), .blen_client(blen_client), .blen_value(blen_value),
    .gnt(gnt), .gnt_owned(gnt_owned), .slot_ptr(slot_ptr)
  );

  always #2 clk = ~clk;

  // reference model
  int m_tbl [NS];
  int m_lim [NC];
  int m_ptr, m_gid, m_cnt, m_owned;
  bit started = 0;
  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  always @(posedge clk) begin
    int e, lo;
    started <= 1;
    if (rst) begin
      m_ptr = 0; m_gid = -1; m_cnt = 0; m_owned = 0;
      foreach (m_tbl[i]) m_tbl[i] = 15;
      foreach (m_lim[i]) m_lim[i] = 3;
    end else begin
      if (m_gid >= 0) begin
        if (beat_valid) begin
          if (beat_last || m_cnt >= m_lim[m_gid]) begin
            m_gid = -1; m_cnt = 0; m_owned = 0; m_ptr = (m_ptr + 1) % NS;
          end else m_cnt++;
        end
      end else if (req != 0) begin
        e = m_tbl[m_ptr];
        lo = -1;
        for (int i = NC - 1; i >= 0; i--) if (req[i]) lo = i;
        if (e < NC && req[e]) begin m_gid = e; m_owned = 1; end
        else begin m_gid = lo; m_owned = 0; end
        m_cnt = 0;
      end
      if (slot_we) m_tbl[slot_addr] = slot_client;
      if (blen_we && blen_client < NC) m_lim[blen_client] = blen_value;
    end
  end

  always @(negedge clk) begin
    logic [14:0] exp_g;
    cycles++;
    if (started) begin
      exp_g = (m_gid >= 0) ? (15'd1 << m_gid) : 15'd0;
      vectors++;
      if (gnt !== exp_g || gnt_owned !== m_owned[0] || slot_ptr !== 6'(m_ptr)) begin
        errors++;
        $display("FAIL %s: gnt=%h owned=%b ptr=%0d expected gnt=%h owned=%0d ptr=%0d",
                 tag, gnt, gnt_owned, slot_ptr, exp_g, m_owned, m_ptr);
      end
      vectors++;
      if ($countones(gnt) > 1) begin
        errors++;
        $display("FAIL R5: gnt=%h expected at most one bit", gnt);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic step(input logic [14:0] r, input logic bv, input logic bl);
    req = r; beat_valid = bv; beat_last = bl;
    @(negedge clk);
    slot_we = 1'b0; blen_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values, empty table
    tag = "R1";
    rst = 1'b0;
    step('0, 0, 0);
    step('0, 0, 0);
    // R3 and R4: empty table resolves to lowest requester
    tag = "R4";
    for (int i = 0; i < 20; i++) step(15'b000_0000_0010_0100, 1, 1);
    // R9: program table at run time
    tag = "R9";
    for (int s = 0; s < NS; s++) begin
      slot_we = 1'b1; slot_addr = 6'(s);
      slot_client = (s % 8 == 5) ? 4'd15 : 4'((s * 7) % 15);
      step(15'b000_1000_0000_0001, 1, (s % 3) == 0);
    end
    // R2: all requesting, owners win
    tag = "R2";
    for (int i = 0; i < 80; i++) step('1, 1, 1);
    // R3: subsets
    tag = "R3";
    for (int i = 0; i < 200; i++) step(15'($urandom), 1, 1);
    // R7: defaults and rewritten limits
    tag = "R7";
    for (int i = 0; i < 40; i++) step('1, 1, 0);
    blen_we = 1'b1; blen_client = 4'd0; blen_value = 4'd0; step('1, 1, 0);
    blen_we = 1'b1; blen_client = 4'd7; blen_value = 4'd7; step('1, 1, 0);
    for (int i = 0; i < 150; i++) step('1, 1, 0);
    // R6: gaps in beats
    tag = "R6";
    for (int i = 0; i < 200; i++) step('1, ($urandom % 3) == 0, 0);
    // R8: idle, pointer holds
    tag = "R8";
    for (int i = 0; i < 40; i++) step('0, 1, 1);
    // R10: mixed random traffic with writes
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 6 == 0) begin
        slot_we = 1'b1; slot_addr = 6'($urandom); slot_client = 4'($urandom);
      end
      if ($urandom % 40 == 0) begin
        blen_we = 1'b1; blen_client = 4'($urandom % 15); blen_value = 4'($urandom);
      end
      step(($urandom % 5 == 0) ? 15'd0 : 15'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0);
    end
    // R1: mid-run reset
    tag = "R1";
    rst = 1'b1;
    step('1, 1, 0);
    step('1, 1, 0);
    rst = 1'b0;
    step('0, 0, 0);
    tag = "R4";
    for (int i = 0; i < 30; i++) step(15'($urandom), 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule